// File: doc/BRIEF.md
# Byte-Serial Instruction Fetch Sequencer

This block fetches instructions of a fixed 32-bit format through a memory port that is only one byte wide. Each instruction has four byte fields: an operation code, a first source selector, a second source selector and a destination selector. Either source selector may name a register or carry a literal value; this block does not interpret them. The block reads the four bytes one access at a time, places each in its own holding register, and only when all four are held does it hand the complete instruction to the downstream datapath with a single-cycle launch pulse.

After the launch the sequencer waits for the datapath to report completion. The staged fields and the program counter stay frozen during that wait. When completion arrives, fetching resumes at the next byte address, or at a target address if a jump is requested in the same cycle. The order is strictly linear: fetch four bytes, launch, wait, repeat. A memory ready input can stretch any byte access by any number of cycles.

Top module: `byte_fetch_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the program counter to 0, clears all four staged fields to 0, holds `exec_go` low and leaves the block fetching byte 0, with `mem_rd` high and `mem_addr` equal to 0 once reset is released.
- R2: The byte read from instruction address A+0 appears on `ins_op`, A+1 on `ins_a`, A+2 on `ins_b` and A+3 on `ins_dst`.
- R3: While fetching, `mem_addr` equals the program counter; it rises by one for each byte accepted (a clock edge with `mem_rd` and `mem_rdy` both high), wraps modulo 65536, and so advances by four per instruction.
- R4: An edge with `mem_rdy` low during a fetch changes neither the program counter, `mem_addr`, the fetch position nor any staged field.
- R5: `exec_go` rises in the cycle after the fourth byte is accepted and is high for exactly one cycle per instruction.
- R6: From the `exec_go` cycle until `exec_done` is taken, the four staged fields and `pc` stay unchanged and `mem_rd` stays low.
- R7: `exec_done` high at an edge while waiting resumes fetching in the next cycle at the byte following the launched instruction.
- R8: `jump_en` high together with `exec_done` while waiting loads `jump_tgt` into the program counter, so the next fetch starts at that address.
- R9: `jump_en` and `exec_done` have no effect while the block is fetching or in the `exec_go` cycle, and `jump_en` without `exec_done` has no effect while waiting.
- R10: `mem_rd` is high in every fetch cycle and low in the launch and wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte address of the current read |
| mem_data | input | 8 | Byte returned by memory for `mem_addr` |
| mem_rdy | input | 1 | Memory accepts the read this cycle |
| pc | output | 16 | Program counter (next byte address) |
| ins_op | output | 8 | Staged operation code field |
| ins_a | output | 8 | Staged first source selector |
| ins_b | output | 8 | Staged second source selector |
| ins_dst | output | 8 | Staged destination selector |
| exec_go | output | 1 | One-cycle launch of the staged instruction |
| exec_done | input | 1 | Datapath finished the launched instruction |
| jump_en | input | 1 | Take `jump_tgt` as the next fetch address on completion |
| jump_tgt | input | 16 | Jump target byte address |

## Verification
The fetch loop is driven with memory that is always ready, with a stall inserted before each of the four byte positions in turn, and with completion that arrives at once or only after several wait cycles; the stall cases separate a design that advances on a stalled edge from one that holds, and the long waits expose staged fields or counters that drift before completion. Jumps are exercised to a mid-range address and to the top of the address space, where the following sequential fetch must wrap to 0. Jump and completion inputs are also pulsed during fetch and during the wait without completion, which tells apart a design that samples them only in the proper cycle from one that reacts early.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [1:0] {
    M_FETCH = 2'd0,
    M_EXEC  = 2'd1,
    M_WAIT  = 2'd2
  } mode_t;

  function automatic mode_t mode_after(input mode_t cur, input logic rdy,
                                       input logic last, input logic done);
    mode_t nxt;
    nxt = cur;
    case (cur)
      M_FETCH: if (rdy && last) nxt = M_EXEC;
      M_EXEC:  nxt = M_WAIT;
      M_WAIT:  if (done) nxt = M_FETCH;
      default: nxt = M_FETCH;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
#(
  parameter int NB = 4,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_rdy,
  input  logic          exec_done,
  output logic [PW-1:0] phase,
  output logic          byte_accept,
  output logic          done_take,
  output logic          go,
  output logic          rd_en
);

  localparam logic [PW-1:0] LAST = PW'(NB - 1);

  mode_t mode;
  logic  at_last;

  assign at_last     = (phase == LAST);
  assign rd_en       = (mode == M_FETCH);
  assign byte_accept = rd_en && mem_rdy;
  assign go          = (mode == M_EXEC);
  assign done_take   = (mode == M_WAIT) && exec_done;

  function automatic logic [PW-1:0] phase_after(input logic [PW-1:0] p,
                                                input logic acc);
    if (!acc) return p;
    if (p == LAST) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= M_FETCH;
      phase <= '0;
    end else begin
      mode  <= mode_after(mode, mem_rdy, at_last, exec_done);
      phase <= phase_after(phase, byte_accept);
    end
  end

  a_r5_go_single: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);

  a_r5_go_after_last: assert property (@(posedge clk) disable iff (rst)
    (byte_accept && at_last) |=> go);

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mem_rdy) |=> (rd_en && $stable(phase)));

  a_r6_wait_no_read: assert property (@(posedge clk) disable iff (rst)
    (go || (!rd_en && !done_take && $past(go || !rd_en))) |=> !byte_accept);

endmodule

// File: rtl/bfs_pc.sv
module bfs_pc #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_accept,
  input  logic          done_take,
  input  logic          jump_en,
  input  logic [AW-1:0] jump_tgt,
  output logic          jump_take,
  output logic [AW-1:0] pc
);

  assign jump_take = done_take && jump_en;

  function automatic logic [AW-1:0] pc_after(input logic [AW-1:0] cur,
                                             input logic step,
                                             input logic jmp,
                                             input logic [AW-1:0] tgt);
    if (jmp)  return tgt;
    if (step) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_after(pc, byte_accept, jump_take, jump_tgt);
  end

  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    byte_accept |=> (pc == $past(pc) + AW'(1)));

  a_r8_jump_load: assert property (@(posedge clk) disable iff (rst)
    jump_take |=> (pc == $past(jump_tgt)));

  a_r9_pc_idle: assert property (@(posedge clk) disable iff (rst)
    (!byte_accept && !jump_take) |=> $stable(pc));

  a_r9_no_step_on_jump: assert property (@(posedge clk) disable iff (rst)
    !(byte_accept && done_take));

endmodule

// File: rtl/bfs_stage.sv
module bfs_stage #(
  parameter int NB = 4,
  parameter int DW = 8,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_accept,
  input  logic [PW-1:0]    phase,
  input  logic [DW-1:0]    din,
  output logic [NB*DW-1:0] staged
);

  logic [NB-1:0] wr_en;

  for (genvar i = 0; i < NB; i++) begin : g_slot
    logic [DW-1:0] slot_q;

    assign wr_en[i] = byte_accept && (phase == PW'(i));

    always_ff @(posedge clk) begin
      if (rst)           slot_q <= '0;
      else if (wr_en[i]) slot_q <= din;
    end

    assign staged[i*DW +: DW] = slot_q;
  end

  a_r2_one_slot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  a_r4_slots_hold: assert property (@(posedge clk) disable iff (rst)
    !byte_accept |=> $stable(staged));

  a_r2_slot_capture: assert property (@(posedge clk) disable iff (rst)
    (byte_accept && phase == '0) |=> (staged[DW-1:0] == $past(din)));

endmodule

// File: rtl/byte_fetch_seq.sv
module byte_fetch_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  input  logic          mem_rdy,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ins_op,
  output logic [DW-1:0] ins_a,
  output logic [DW-1:0] ins_b,
  output logic [DW-1:0] ins_dst,
  output logic          exec_go,
  input  logic          exec_done,
  input  logic          jump_en,
  input  logic [AW-1:0] jump_tgt
);

  localparam int NB = 4;
  localparam int PW = $clog2(NB);

  logic [PW-1:0]    phase;
  logic             byte_accept;
  logic             done_take;
  logic             jump_take;
  logic [NB*DW-1:0] staged;

  bfs_ctrl #(.NB(NB)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .mem_rdy     (mem_rdy),
    .exec_done   (exec_done),
    .phase       (phase),
    .byte_accept (byte_accept),
    .done_take   (done_take),
    .go          (exec_go),
    .rd_en       (mem_rd)
  );

  bfs_pc #(.AW(AW)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .byte_accept (byte_accept),
    .done_take   (done_take),
    .jump_en     (jump_en),
    .jump_tgt    (jump_tgt),
    .jump_take   (jump_take),
    .pc          (pc)
  );

  bfs_stage #(.NB(NB), .DW(DW)) u_stage (
    .clk         (clk),
    .rst         (rst),
    .byte_accept (byte_accept),
    .phase       (phase),
    .din         (mem_data),
    .staged      (staged)
  );

  assign mem_addr = pc;
  assign ins_op   = staged[0*DW +: DW];
  assign ins_a    = staged[1*DW +: DW];
  assign ins_b    = staged[2*DW +: DW];
  assign ins_dst  = staged[3*DW +: DW];

  a_r6_frozen_wait: assert property (@(posedge clk) disable iff (rst)
    exec_go |=> ($stable(staged) && $stable(pc) && !mem_rd));

  a_r7_resume: assert property (@(posedge clk) disable iff (rst)
    (done_take && !jump_take) |=> (mem_rd && mem_addr == $past(pc)));

endmodule

// File: tb/byte_fetch_seq_tb.sv
module byte_fetch_seq_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_rdy;
  logic [15:0] pc;
  logic [7:0]  ins_op, ins_a, ins_b, ins_dst;
  logic        exec_go;
  logic        exec_done;
  logic        jump_en;
  logic [15:0] jump_tgt;

  int checks = 0;
  int errors = 0;
  logic [47:0] exp_q[$];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] lo;
    lo = a[7:0];
    return ((lo << 5) + (lo << 2) + lo + 8'd11) ^ a[15:8];
  endfunction

  assign mem_data = mem_byte(mem_addr);

  byte_fetch_seq u_dut (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_rdy(mem_rdy), .pc(pc),
    .ins_op(ins_op), .ins_a(ins_a), .ins_b(ins_b), .ins_dst(ins_dst),
    .exec_go(exec_go), .exec_done(exec_done), .jump_en(jump_en),
    .jump_tgt(jump_tgt)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: compare each launched instruction with the scoreboard
  always @(negedge clk) begin
    if (!rst && exec_go) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected launch", 32'd1, 32'd0);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        chk("R2 op field",   {24'd0, ins_op},  {24'd0, e[31:24]});
        chk("R2 a field",    {24'd0, ins_a},   {24'd0, e[23:16]});
        chk("R2 b field",    {24'd0, ins_b},   {24'd0, e[15:8]});
        chk("R2 dst field",  {24'd0, ins_dst}, {24'd0, e[7:0]});
        chk("R3 pc at launch", {16'd0, pc},    {16'd0, e[47:32]});
      end
    end
  end

  // driver: one instruction, entered and left at a negedge in fetch byte 0
  task automatic run_instr(input logic [15:0] start, input int stall_at,
                           input int hold, input bit jmp,
                           input logic [15:0] tgt, input bit noise);
    logic [15:0] nxt;
    exp_q.push_back({start + 16'd4, mem_byte(start), mem_byte(start + 16'd1),
                     mem_byte(start + 16'd2), mem_byte(start + 16'd3)});
    jump_en   = noise;
    exec_done = noise;
    jump_tgt  = 16'hBEEF;
    for (int k = 0; k < 4; k++) begin
      if (k == stall_at) begin
        mem_rdy = 1'b0;
        repeat (3) begin
          @(negedge clk);
          chk("R4 addr held in stall", {16'd0, mem_addr}, {16'd0, start + 16'(k)});
          chk("R10 read during stall", {31'd0, mem_rd}, 32'd1);
        end
        mem_rdy = 1'b1;
      end
      chk("R3 fetch address", {16'd0, mem_addr}, {16'd0, start + 16'(k)});
      chk("R10 read in fetch", {31'd0, mem_rd}, 32'd1);
      chk("R9 no early launch", {31'd0, exec_go}, 32'd0);
      @(negedge clk);
    end
    jump_en   = 1'b0;
    exec_done = 1'b0;
    chk("R5 launch pulse", {31'd0, exec_go}, 32'd1);
    chk("R10 no read at launch", {31'd0, mem_rd}, 32'd0);
    @(negedge clk);
    chk("R5 launch one cycle", {31'd0, exec_go}, 32'd0);
    jump_en  = 1'b1;
    jump_tgt = 16'h1234;
    for (int h = 0; h < hold; h++) begin
      chk("R6 op frozen",  {24'd0, ins_op},  {24'd0, mem_byte(start)});
      chk("R6 dst frozen", {24'd0, ins_dst}, {24'd0, mem_byte(start + 16'd3)});
      chk("R6 pc frozen",  {16'd0, pc}, {16'd0, start + 16'd4});
      chk("R6 no read in wait", {31'd0, mem_rd}, 32'd0);
      @(negedge clk);
    end
    chk("R9 jump without done ignored", {16'd0, pc}, {16'd0, start + 16'd4});
    exec_done = 1'b1;
    jump_en   = jmp;
    jump_tgt  = tgt;
    @(negedge clk);
    exec_done = 1'b0;
    jump_en   = 1'b0;
    nxt = jmp ? tgt : start + 16'd4;
    if (jmp) chk("R8 jump target fetch", {16'd0, mem_addr}, {16'd0, nxt});
    else     chk("R7 resume next byte",  {16'd0, mem_addr}, {16'd0, nxt});
    chk("R7 read resumes", {31'd0, mem_rd}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst       = 1'b1;
    mem_rdy   = 1'b1;
    exec_done = 1'b0;
    jump_en   = 1'b0;
    jump_tgt  = 16'h0;
    repeat (3) @(negedge clk);
    chk("R1 pc cleared", {16'd0, pc}, 32'd0);
    chk("R1 fields cleared", {ins_op, ins_a, ins_b, ins_dst}, 32'd0);
    chk("R1 no launch", {31'd0, exec_go}, 32'd0);
    rst = 1'b0;
    chk("R1 read at 0", {15'd0, mem_rd, mem_addr}, 32'h0001_0000);

    run_instr(16'h0000, -1, 0, 1'b0, 16'h0, 1'b0);
    run_instr(16'h0004, 2, 3, 1'b0, 16'h0, 1'b1);
    run_instr(16'h0008, 0, 1, 1'b1, 16'h0040, 1'b1);
    run_instr(16'h0040, 3, 2, 1'b1, 16'hFFFC, 1'b0);
    run_instr(16'hFFFC, 1, 0, 1'b0, 16'h0, 1'b1);
    run_instr(16'h0000, -1, 4, 1'b0, 16'h0, 1'b0);

    chk("R5 all launches seen", exp_q.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule